// File: doc/BRIEF.md
# Cascadable Active-Low Priority Encoder

This block turns a bank of active-low request lines into the binary index of the most significant pending request. It is built from identical 8-input slices. Each slice has an active-low enable in, an active-low pass-enable out and an active-low "slice has a request" flag. Slices form a chain from the most significant one down. A slice that sees a request drives its pass-enable high, which shuts off every slice below it. A slice that is enabled but idle keeps its pass-enable low, so the slice below it is enabled.

The top level chains two slices into a 16-input encoder. The upper slice takes the external enable. The upper slice's request flag, inverted, is result bit 3. The two slices' active-low codes are ANDed and then inverted to give result bits 2..0. This works because a disabled or idle slice holds its code at all ones. The block is purely combinational and has no clock or reset.

Top module: `penc16_chain`

## Requirements
- R1: While `chain_en_n` is 0, request i is pending when `req_n[i]` is 0, and `req_idx` equals the highest pending index i (0..15).
- R2: While `chain_en_n` is 1, `req_idx` is 0000, `any_req_n` is 1 and `pass_en_n` is 1, whatever `req_n` holds.
- R3: While enabled with all `req_n` bits at 1, `req_idx` is 0000, `any_req_n` is 1 and `pass_en_n` is 0.
- R4: While enabled with at least one request pending, `any_req_n` is 0 and `pass_en_n` is 1.
- R5: While enabled, `req_idx[3]` is 1 exactly when some request in 8..15 is pending.
- R6: While any request in 8..15 is pending, requests 0..7 have no effect: `req_idx[2:0]` is the highest pending index minus 8.
- R7: While no request in 8..15 is pending, `req_idx[2:0]` is the highest pending index among 0..7.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| chain_en_n | input | 1 | Active-low enable for the whole encoder |
| req_n | input | 16 | Active-low request lines; bit 15 has the highest priority |
| req_idx | output | 4 | Active-high index of the highest pending request |
| any_req_n | output | 1 | Low when the encoder is enabled and a request is pending |
| pass_en_n | output | 1 | Active-low enable for a further, lower-priority stage |

## Verification
The bench uses the default slice width of 8, which gives a 16-input encoder. With enable low it applies all 65536 request patterns, so every priority position and every masking of the lower slice by the upper one is covered. With enable high it applies a stride through the same space to show that requests have no effect. Expected index, flag and pass-enable come from a highest-set-bit computation in the bench.

// File: rtl/penc_pkg.sv
package penc_pkg;
    localparam int unsigned PENC_SLICE_W_DEF = 8;

    // number of index bits needed for a slice of w inputs
    function automatic int unsigned idx_bits(input int unsigned w);
        return (w < 2) ? 1 : $clog2(w);
    endfunction
endpackage

// File: rtl/penc_slice.sv
module penc_slice
    import penc_pkg::*;
#(
    parameter int unsigned SLICE_W = PENC_SLICE_W_DEF,
    localparam int unsigned SEL_W = idx_bits(SLICE_W)
) (
    input  logic               sl_en_n,
    input  logic [SLICE_W-1:0] sl_req_n,
    output logic [SEL_W-1:0]   sl_idx_n,
    output logic               sl_hit_n,
    output logic               sl_pass_n
);
    logic             hit;
    logic [SEL_W-1:0] idx;

    // priority scan: later (higher) indices overwrite earlier ones
    always_comb begin
        hit = 1'b0;
        idx = '0;
        for (int i = 0; i < int'(SLICE_W); i++) begin
            if (!sl_req_n[i]) begin
                hit = 1'b1;
                idx = SEL_W'(i);
            end
        end
    end

    // output stage: disabled slice parks everything high
    always_comb begin
        if (sl_en_n) begin
            sl_idx_n  = '1;
            sl_hit_n  = 1'b1;
            sl_pass_n = 1'b1;
        end else begin
            sl_idx_n  = ~idx;
            sl_hit_n  = ~hit;
            sl_pass_n = hit;
        end
    end

    // R4: an enabled slice never both flags a request and passes enable on
    always_comb begin
        if (!$isunknown({sl_en_n, sl_hit_n, sl_pass_n}) && !sl_en_n)
            a_r4_hit_blocks_pass: assert (sl_hit_n != sl_pass_n)
                else $error("slice hit/pass conflict");
    end

    // R3: an idle slice leaves its code at all ones
    always_comb begin
        if (!$isunknown({sl_hit_n, sl_idx_n}) && sl_hit_n)
            a_r3_idle_code_high: assert (sl_idx_n == '1)
                else $error("idle slice drives code");
    end
endmodule

// File: rtl/penc_merge.sv
module penc_merge
    import penc_pkg::*;
#(
    parameter int unsigned SEL_W = idx_bits(PENC_SLICE_W_DEF),
    localparam int unsigned CODE_W = SEL_W + 1
) (
    input  logic [SEL_W-1:0]  hi_idx_n,
    input  logic              hi_hit_n,
    input  logic [SEL_W-1:0]  lo_idx_n,
    input  logic              lo_hit_n,
    input  logic              lo_pass_n,
    output logic [CODE_W-1:0] idx,
    output logic              any_n,
    output logic              pass_n
);
    always_comb begin
        idx    = {~hi_hit_n, ~(hi_idx_n & lo_idx_n)};
        any_n  = hi_hit_n & lo_hit_n;
        pass_n = lo_pass_n;
    end

    // R6: an upper request leaves the lower slice silent
    always_comb begin
        if (!$isunknown({hi_hit_n, lo_idx_n, lo_hit_n}) && !hi_hit_n)
            a_r6_lower_masked: assert (lo_idx_n == '1 && lo_hit_n)
                else $error("lower slice active under upper request");
    end
endmodule

// File: rtl/penc16_chain.sv
module penc16_chain
    import penc_pkg::*;
#(
    parameter int unsigned SLICE_W = PENC_SLICE_W_DEF,
    localparam int unsigned SEL_W  = idx_bits(SLICE_W),
    localparam int unsigned REQ_W  = 2 * SLICE_W,
    localparam int unsigned CODE_W = SEL_W + 1
) (
    input  logic              chain_en_n,
    input  logic [REQ_W-1:0]  req_n,
    output logic [CODE_W-1:0] req_idx,
    output logic              any_req_n,
    output logic              pass_en_n
);
    logic [SEL_W-1:0] hi_idx_n, lo_idx_n;
    logic             hi_hit_n, lo_hit_n;
    logic             hi_pass_n, lo_pass_n;

    penc_slice #(.SLICE_W(SLICE_W)) upper_i (
        .sl_en_n  (chain_en_n),
        .sl_req_n (req_n[REQ_W-1:SLICE_W]),
        .sl_idx_n (hi_idx_n),
        .sl_hit_n (hi_hit_n),
        .sl_pass_n(hi_pass_n)
    );

    penc_slice #(.SLICE_W(SLICE_W)) lower_i (
        .sl_en_n  (hi_pass_n),
        .sl_req_n (req_n[SLICE_W-1:0]),
        .sl_idx_n (lo_idx_n),
        .sl_hit_n (lo_hit_n),
        .sl_pass_n(lo_pass_n)
    );

    penc_merge #(.SEL_W(SEL_W)) merge_i (
        .hi_idx_n (hi_idx_n),
        .hi_hit_n (hi_hit_n),
        .lo_idx_n (lo_idx_n),
        .lo_hit_n (lo_hit_n),
        .lo_pass_n(lo_pass_n),
        .idx      (req_idx),
        .any_n    (any_req_n),
        .pass_n   (pass_en_n)
    );

    // R2: a disabled chain drives all outputs inactive
    always_comb begin
        if (!$isunknown({chain_en_n, req_idx, any_req_n, pass_en_n}) && chain_en_n)
            a_r2_disabled_quiet: assert (req_idx == '0 && any_req_n && pass_en_n)
                else $error("disabled chain not quiet");
    end

    // R5: top index bit set means the lower slice is shut off
    always_comb begin
        if (!$isunknown({req_idx, hi_pass_n, lo_hit_n}) && req_idx[CODE_W-1])
            a_r5_top_bit_blocks_lower: assert (hi_pass_n && lo_hit_n)
                else $error("top bit set with lower slice live");
    end
endmodule

// File: tb/penc16_chain_tb_top.sv
module penc16_chain_tb_top;
    logic        clk = 1'b0;
    logic        chain_en_n;
    logic [15:0] req_n;
    logic [3:0]  req_idx;
    logic        any_req_n, pass_en_n;
    int          n_cmp = 0, n_bad = 0;
    bit          done = 1'b0;

    always #2 clk = ~clk;

    penc16_chain dut_i (
        .chain_en_n(chain_en_n),
        .req_n     (req_n),
        .req_idx   (req_idx),
        .any_req_n (any_req_n),
        .pass_en_n (pass_en_n)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s en_n=%0b req_n=%h actual=%0d expected=%0d",
                     tag, chain_en_n, req_n, act, exp);
        end
    endtask

    task automatic apply(input logic en, input logic [15:0] rn);
        logic [15:0] r;
        int          top;
        @(negedge clk);
        chain_en_n = en;
        req_n      = rn;
        @(posedge clk);
        #1;
        r   = ~rn;
        top = -1;
        for (int i = 0; i < 16; i++) if (r[i]) top = i;
        if (en) begin
            chk("R2 idx", int'(req_idx), 0);
            chk("R2 any", int'(any_req_n), 1);
            chk("R2 pass", int'(pass_en_n), 1);
        end else if (top < 0) begin
            chk("R3 idx", int'(req_idx), 0);
            chk("R3 any", int'(any_req_n), 1);
            chk("R3 pass", int'(pass_en_n), 0);
        end else begin
            chk("R1 idx", int'(req_idx), top);
            chk("R4 any", int'(any_req_n), 0);
            chk("R4 pass", int'(pass_en_n), 1);
            chk("R5 bit3", int'(req_idx[3]), (top >= 8) ? 1 : 0);
            if (top >= 8) chk("R6 low bits", int'(req_idx[2:0]), top - 8);
            else          chk("R7 low bits", int'(req_idx[2:0]), top);
        end
    endtask

    initial begin
        chain_en_n = 1'b1;
        req_n      = '1;
        apply(1'b1, 16'hFFFF);           // idle, disabled
        for (int p = 0; p < 65536; p++)  // R1, R3..R7 exhaustive
            apply(1'b0, 16'(p));
        for (int p = 0; p < 65536; p += 29) // R2 with requests present
            apply(1'b1, 16'(p));
        apply(1'b1, 16'h0000);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule